// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is the three-wire programming port of a clock synthesizer. A serial clock, a data line and a load strobe move a 15-bit configuration word into the block. The word sets a 9-bit feedback divider value, a 3-bit output divider code, a 2-bit test selector and a spread-spectrum enable. The port also drives a test pin through a four-way selector. That pin can show a constant low, the serial data line, or one of two clock-like signals that come from outside the block.

All state is clocked by the serial clock. The load strobe is registered in that domain so that its edges can be detected. While the strobe is low, bits shift in and the applied configuration stays as it is. When the strobe rises, the accumulated word is transferred to the outputs. While the strobe stays high, each clock shifts one more bit, and the outputs follow the shifted word. When the strobe falls, the last value is kept. A status output reports whether the applied feedback divider lies in the range where the loop can lock. Out-of-range values are still applied.

Top module: `serial_synth_cfg`

## Requirements
- R1: On every rising `s_clock` edge while `s_load` is low, the shift register moves one place toward its MSB and takes `s_data` into bit 0. The first bit sent therefore reaches bit 14 after 15 clocks. Word layout: bits 14:13 test select, bits 12:10 output divider code, bits 9:1 feedback divider (bit 9 is its MSB), bit 0 spread-spectrum enable.
- R2: On the first clock at which `s_load` is sampled high after being sampled low, the outputs take the shift register contents, and the shift register does not shift on that clock.
- R3: On each later clock with `s_load` still high, the shift register shifts in `s_data` as in R1, and the outputs take the shifted word on that same clock.
- R4: On any clock with `s_load` sampled low, including the first clock after it falls, the outputs keep their value while bits shift in.
- R5: An active-low asynchronous reset sets the feedback divider to 192, the output divider code to 001 (divide-by-2), the test select to 00 and spread spectrum to off. It clears the shift register and the registered strobe.
- R6: `test_out` is combinational from the applied test select: 00 gives 0, 01 gives `s_data`, 10 gives `fb_div_in`, 11 gives `fout_in`.
- R7: `m_valid` is 1 exactly when the applied feedback divider is between 120 and 240 inclusive. A value outside that range still appears on `m_div`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| s_clock | input | 1 | Serial clock, the only clock of the block |
| s_data | input | 1 | Serial data, MSB first |
| s_load | input | 1 | Load strobe |
| fb_div_in | input | 1 | Feedback divider output, routed to the test pin |
| fout_in | input | 1 | Output clock, routed to the test pin |
| m_div | output | 9 | Applied feedback divider value |
| n_div | output | 3 | Applied output divider code |
| t_sel | output | 2 | Applied test select |
| ssc_en | output | 1 | Applied spread-spectrum enable |
| m_valid | output | 1 | Feedback divider lies in the lockable range |
| test_out | output | 1 | Selected test signal |

## Verification
The clock on which the strobe is first seen high is the most delicate case. On that clock the transfer to the outputs and the arrival of a new data bit coincide, and the design must transfer the old word and drop the new bit instead of shifting it in. The bench drives a distinct data bit on every such capture clock. It then compares the outputs, and later the contents of the shift register as they emerge in a following word, with an independent model. A second coincidence appears when a word applied transparently switches the test select to the data line: on that same clock, `test_out` must already follow `s_data`. The bench checks this after every clock.

// File: rtl/syncfg_pkg.sv
package syncfg_pkg;
    localparam int unsigned T_W = 2;
    localparam int unsigned N_W = 3;
    localparam int unsigned M_W = 9;
    localparam int unsigned WORD_W = T_W + N_W + M_W + 1;

    localparam logic [M_W-1:0] M_DEFAULT = 9'd192;
    localparam logic [N_W-1:0] N_DEFAULT = 3'b001;
    localparam logic [M_W-1:0] M_LOCK_MIN = 9'd120;
    localparam logic [M_W-1:0] M_LOCK_MAX = 9'd240;

    typedef struct packed {
        logic [T_W-1:0] tsel;
        logic [N_W-1:0] ndiv;
        logic [M_W-1:0] mdiv;
        logic           ssc;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{tsel: '0, ndiv: N_DEFAULT, mdiv: M_DEFAULT, ssc: 1'b0};
endpackage

// File: rtl/syncfg_shift.sv
module syncfg_shift #(
    parameter int unsigned WORD_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              freeze,
    output logic [WORD_W-1:0] sr_q,
    output logic [WORD_W-1:0] sr_next
);
    logic [WORD_W-1:0] sr_d;

    always_comb begin
        sr_next = {sr_q[WORD_W-2:0], ser_bit};
        sr_d    = freeze ? sr_q : sr_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assert_shift_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> sr_q == {$past(sr_q[WORD_W-2:0]), $past(ser_bit)});

    assert_no_shift_on_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(sr_q));
endmodule

// File: rtl/syncfg_hold.sv
module syncfg_hold
    import syncfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_in,
    input  logic [WORD_W-1:0] sr_q,
    input  logic [WORD_W-1:0] sr_next,
    output logic              capture,
    output cfg_t              cfg_q
);
    typedef struct packed {
        logic load;
        cfg_t cfg;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = load_in;
        capture   = load_in && !st_q.load;
        if (capture)      st_d.cfg = cfg_t'(sr_q);
        else if (load_in) st_d.cfg = cfg_t'(sr_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{load: 1'b0, cfg: CFG_RESET};
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;

    assert_capture_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_in && !st_q.load) |=> cfg_q == cfg_t'($past(sr_q)));

    assert_transparent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_in && st_q.load) |=> cfg_q == cfg_t'({$past(sr_q[WORD_W-2:0]), $past(sr_next[0])}));

    assert_hold_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_in |=> $stable(cfg_q));
endmodule

// File: rtl/syncfg_testmux.sv
module syncfg_testmux #(
    parameter int unsigned SEL_W = 2
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [(1<<SEL_W)-1:0] src,
    output logic                  y
);
    localparam int unsigned NSRC = 1 << SEL_W;
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = (sel == SEL_W'(i)) && src[i];
    end

    assign y = |hit;
endmodule

// File: rtl/serial_synth_cfg.sv
module serial_synth_cfg
    import syncfg_pkg::*;
(
    input  logic           rst_n,
    input  logic           s_clock,
    input  logic           s_data,
    input  logic           s_load,
    input  logic           fb_div_in,
    input  logic           fout_in,
    output logic [M_W-1:0] m_div,
    output logic [N_W-1:0] n_div,
    output logic [T_W-1:0] t_sel,
    output logic           ssc_en,
    output logic           m_valid,
    output logic           test_out
);
    logic [WORD_W-1:0] sr_q, sr_next;
    logic              capture;
    cfg_t              cfg;

    syncfg_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(s_clock), .rst_n(rst_n), .ser_bit(s_data), .freeze(capture),
        .sr_q(sr_q), .sr_next(sr_next)
    );

    syncfg_hold u_hold (
        .clk(s_clock), .rst_n(rst_n), .load_in(s_load), .sr_q(sr_q),
        .sr_next(sr_next), .capture(capture), .cfg_q(cfg)
    );

    syncfg_testmux #(.SEL_W(T_W)) u_mux (
        .sel(cfg.tsel), .src({fout_in, fb_div_in, s_data, 1'b0}), .y(test_out)
    );

    assign m_div   = cfg.mdiv;
    assign n_div   = cfg.ndiv;
    assign t_sel   = cfg.tsel;
    assign ssc_en  = cfg.ssc;
    assign m_valid = (cfg.mdiv >= M_LOCK_MIN) && (cfg.mdiv <= M_LOCK_MAX);

    assert_test_low_R6: assert property (@(posedge s_clock) disable iff (!rst_n)
        (t_sel == 2'b00) |-> !test_out);

    assert_valid_bounds_R7: assert property (@(posedge s_clock) disable iff (!rst_n)
        (m_div < M_LOCK_MIN) |-> !m_valid);
endmodule

// File: tb/sim_serial_synth_cfg.sv
module sim_serial_synth_cfg;
    logic rst_n = 1'b0, s_clock = 1'b0, s_data = 1'b0, s_load = 1'b0;
    logic fb_div_in = 1'b0, fout_in = 1'b0;
    logic [8:0] m_div;
    logic [2:0] n_div;
    logic [1:0] t_sel;
    logic ssc_en, m_valid, test_out;

    int n_cmp = 0, n_bad = 0;
    logic [14:0] msr, mcfg;
    logic mlq;

    always #4 s_clock = ~s_clock;

    serial_synth_cfg u0 (.*);

    // mode: 0 = pulse load, 1 = held high, 2 = low only
    localparam logic [16:0] VEC [0:9] = '{
        {2'd0, 2'b00, 3'b010, 9'd120, 1'b1},
        {2'd0, 2'b01, 3'b101, 9'd240, 1'b0},
        {2'd1, 2'b10, 3'b011, 9'd119, 1'b1},
        {2'd1, 2'b11, 3'b110, 9'd241, 1'b0},
        {2'd2, 2'b01, 3'b111, 9'd5,   1'b1},
        {2'd0, 2'b01, 3'b000, 9'd511, 1'b1},
        {2'd1, 2'b01, 3'b100, 9'd200, 1'b0},
        {2'd0, 2'b11, 3'b001, 9'd0,   1'b0},
        {2'd1, 2'b00, 3'b010, 9'd150, 1'b1},
        {2'd2, 2'b10, 3'b001, 9'd121, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic exp_t;
        case (mcfg[14:13])
            2'b00: exp_t = 1'b0;
            2'b01: exp_t = s_data;
            2'b10: exp_t = fb_div_in;
            default: exp_t = fout_in;
        endcase
        chk({tag, " cfg word"}, {17'd0, t_sel, n_div, m_div, ssc_en}, {17'd0, mcfg});
        chk("R7 m_valid", {31'd0, m_valid}, {31'd0, (mcfg[9:1] >= 9'd120 && mcfg[9:1] <= 9'd240)});
        chk("R6 test_out", {31'd0, test_out}, {31'd0, exp_t});
    endtask

    // called at a negedge; drives, clocks once, updates model, checks at next negedge
    task automatic tick(input logic ld, input logic d, input string tag);
        s_load = ld; s_data = d;
        fb_div_in = 1'($urandom); fout_in = 1'($urandom);
        @(posedge s_clock);
        if (ld && !mlq) mcfg = msr;
        else begin
            msr = {msr[13:0], d};
            if (ld) mcfg = msr;
        end
        mlq = ld;
        @(negedge s_clock);
        #1;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; s_load = 1'b0;
        msr = '0; mlq = 1'b0; mcfg = {2'b00, 3'b001, 9'd192, 1'b0};
        #1;
        chk("R5 m default", {23'd0, m_div}, 32'd192);
        chk("R5 n default", {29'd0, n_div}, 32'd1);
        chk("R5 t/ssc default", {29'd0, t_sel, ssc_en}, 32'd0);
        check_all("R5");
        @(negedge s_clock);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [14:0] w, input int mode);
        if (mode == 1) tick(1'b1, ~w[14], "R2 capture");
        for (int i = 14; i >= 0; i--)
            tick(mode == 1, w[i], mode == 1 ? "R3" : (mode == 2 ? "R4" : "R1"));
        if (mode == 0) begin
            tick(1'b1, ~w[0], "R2 capture");
            chk("R2 word applied", {17'd0, t_sel, n_div, m_div, ssc_en}, {17'd0, w});
        end
        if (mode == 1)
            chk("R3 word applied", {17'd0, t_sel, n_div, m_div, ssc_en}, {17'd0, w});
        tick(1'b0, 1'b1, "R4 fall");
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge s_clock);
        do_reset();
        for (int v = 0; v < 10; v++) send(VEC[v][14:0], int'(VEC[v][16:15]));
        for (int r = 0; r < 40; r++) send(15'($urandom), r % 3);
        // reset mid-shift clears the shift register: a capture then yields zero
        for (int i = 0; i < 7; i++) tick(1'b0, 1'b1, "R1");
        do_reset();
        tick(1'b1, 1'b1, "R5 cleared capture");
        chk("R5 shift cleared", {17'd0, t_sel, n_div, m_div, ssc_en}, 32'd0);
        chk("R7 zero invalid", {31'd0, m_valid}, 32'd0);
        tick(1'b0, 1'b0, "R4");
        // first bit lands in the test-select MSB
        send(15'h4000, 0);
        chk("R1 first bit to bit 14", {30'd0, t_sel}, 32'd2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule